// File: doc/BRIEF.md
# Temperature Node Register File with Window Flags

This block holds the byte-wide registers of a temperature-sensing node and the window comparator that watches its readings. A 2-bit pointer selects one of four registers. These are the last conversion result (read-only), a configuration byte, a lower limit and an upper limit. The bus side presents a pointer, a write strobe with a data byte, and a read strobe. Read data follows the pointer without delay.

When the converter signals that a conversion has finished, the new result is stored in the temperature register. In the same clock cycle the result is compared, as a signed value, against both limits. The outcome sets or clears a high flag and a low flag in the configuration byte. A latch-enable bit in the configuration byte chooses between two behaviours:

- Transparent: each flag tracks the latest comparison.
- Latched: a flag, once raised, stays up until software reads the configuration byte.

A read of the configuration byte clears both flags, whichever behaviour is selected. The conversion-rate and mode fields leave the block as separate outputs so the converter sequencer can use them.

Top module: `tsense_regfile`

## Requirements
- R1: After reset the temperature register reads 0x00, the configuration byte 0x02, the lower limit 0xF6 (-10) and the upper limit 0x3C (+60).
- R2: `bus_rdata` shows, in the same cycle, the register named by `bus_ptr`: 0 temperature, 1 configuration, 2 lower limit, 3 upper limit.
- R3: A write strobe with pointer 1, 2 or 3 updates the addressed register at the next clock edge. A register changes only through its own write.
- R4: Writes with pointer 0 leave the temperature register unchanged. Configuration writes ignore data bits 7, 4 and 3, and bit 7 always reads 0.
- R5: A conversion-done strobe loads `conv_result` into the temperature register at the next edge.
- R6: At each conversion end, the high flag (configuration bit 4) is set when the result is greater than the upper limit, and the low flag (bit 3) is set when the result is less than the lower limit. Both comparisons are signed, and a result equal to a limit does not raise that limit's flag.
- R7: With the latch bit (configuration bit 2) at 0, each flag takes the value of its latest comparison, so a result inside the window clears both flags.
- R8: With the latch bit at 1, a raised flag stays raised through later conversions until the configuration byte is read.
- R9: A read strobe with pointer 1 returns the flags as they were and clears both flags at the next edge. Reads with other pointers leave the flags alone.
- R10: When a conversion end and a configuration read fall in the same cycle, the flags take the new comparison result.
- R11: `rate_out` mirrors configuration bits 6:5 and `mode_out` mirrors bits 1:0. Both are written together with the latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ptr | input | 2 | Register pointer |
| bus_wr | input | 1 | Write strobe, one cycle per complete byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data of the selected register |
| conv_done | input | 1 | Conversion finished strobe |
| conv_result | input | 8 | Signed conversion result, 1 degree per LSB |
| temp_out | output | 8 | Temperature register |
| cfg_out | output | 8 | Configuration byte |
| low_out | output | 8 | Lower limit register |
| high_out | output | 8 | Upper limit register |
| rate_out | output | 2 | Conversion-rate field |
| mode_out | output | 2 | Mode field |

## Verification
The properties take the strobes as known, single-cycle pulses that are sampled on the rising edge. They also assume that a limit changes only through its own write strobe. The flag properties compare the result against the limit values present in the same cycle, so they rely on no limit write falling in the cycle of a conversion end. The bench drives every write, read and conversion in a cycle of its own, with one exception: the collision scenario sets a configuration read and a conversion end together on purpose, and the read-clear property excludes that case.

// File: rtl/tsense_regfile.sv
module tsense_regfile #(
  parameter logic [7:0] LOW_RST  = 8'hF6,
  parameter logic [7:0] HIGH_RST = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_ptr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       conv_done,
  input  logic [7:0] conv_result,
  output logic [7:0] temp_out,
  output logic [7:0] cfg_out,
  output logic [7:0] low_out,
  output logic [7:0] high_out,
  output logic [1:0] rate_out,
  output logic [1:0] mode_out
);
  localparam logic [1:0] P_TEMP = 2'd0;
  localparam logic [1:0] P_CFG  = 2'd1;
  localparam logic [1:0] P_LOW  = 2'd2;
  localparam logic [1:0] P_HIGH = 2'd3;
  localparam logic [1:0] MODE_RST = 2'b10;

  logic [7:0] temp_q, low_q, high_q;
  logic [1:0] rate_q, mode_q;
  logic       lc_q, fh_q, fl_q;

  wire cfg_rd  = bus_rd && (bus_ptr == P_CFG);
  wire cfg_wr  = bus_wr && (bus_ptr == P_CFG);
  wire low_wr  = bus_wr && (bus_ptr == P_LOW);
  wire high_wr = bus_wr && (bus_ptr == P_HIGH);
  wire above   = $signed(conv_result) > $signed(high_q);
  wire below   = $signed(conv_result) < $signed(low_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      low_q  <= LOW_RST;
      high_q <= HIGH_RST;
      rate_q <= '0;
      mode_q <= MODE_RST;
      lc_q   <= 1'b0;
    end else begin
      if (conv_done) temp_q <= conv_result;
      if (low_wr)    low_q  <= bus_wdata;
      if (high_wr)   high_q <= bus_wdata;
      if (cfg_wr) begin
        rate_q <= bus_wdata[6:5];
        lc_q   <= bus_wdata[2];
        mode_q <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fh_q <= 1'b0;
      fl_q <= 1'b0;
    end else if (conv_done) begin
      fh_q <= above | (lc_q & fh_q & ~cfg_rd);
      fl_q <= below | (lc_q & fl_q & ~cfg_rd);
    end else if (cfg_rd) begin
      fh_q <= 1'b0;
      fl_q <= 1'b0;
    end
  end

  assign temp_out = temp_q;
  assign low_out  = low_q;
  assign high_out = high_q;
  assign cfg_out  = {1'b0, rate_q, fh_q, fl_q, lc_q, mode_q};
  assign rate_out = rate_q;
  assign mode_out = mode_q;

  always_comb begin
    case (bus_ptr)
      P_TEMP:  bus_rdata = temp_q;
      P_CFG:   bus_rdata = cfg_out;
      P_LOW:   bus_rdata = low_q;
      default: bus_rdata = high_q;
    endcase
  end
endmodule

// File: rtl/tsense_regfile_chk.sv
module tsense_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_ptr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       conv_done,
  input logic [7:0] conv_result,
  input logic [7:0] temp_out,
  input logic [7:0] cfg_out,
  input logic [7:0] low_out,
  input logic [7:0] high_out
);
  wire rd_cfg = bus_rd && bus_ptr == 2'd1;

  AST_TEMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> temp_out == $past(conv_result)); // R5
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(temp_out)); // R4
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_ptr == 2'd2) |=> $stable(low_out)); // R3
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_ptr == 2'd3) |=> $stable(high_out)); // R3
  AST_FH_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && $signed(conv_result) > $signed(high_out) |=> cfg_out[4]); // R6
  AST_FL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && $signed(conv_result) < $signed(low_out) |=> cfg_out[3]); // R6
  AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !cfg_out[2] && $signed(conv_result) <= $signed(high_out)
      && $signed(conv_result) >= $signed(low_out) |=> cfg_out[4:3] == 2'b00); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out[2] && cfg_out[4] && !rd_cfg |=> cfg_out[4]); // R8
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg && !conv_done |=> cfg_out[4:3] == 2'b00); // R9
  AST_ID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !cfg_out[7]); // R4
endmodule

bind tsense_regfile tsense_regfile_chk u_chk (.*);

// File: tb/tsense_regfile_bench.sv
module tsense_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_ptr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, conv_done = 1'b0;
  logic [7:0] bus_wdata = '0, conv_result = '0;
  logic [7:0] bus_rdata, temp_out, cfg_out, low_out, high_out;
  logic [1:0] rate_out, mode_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsense_regfile u_tsense_regfile (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] p, logic [7:0] d);
    @(negedge clk); bus_ptr = p; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] p, output logic [7:0] d);
    @(negedge clk); bus_ptr = p; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic conv(logic [7:0] v);
    @(negedge clk); conv_result = v; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 temp", temp_out, 8'h00);
    chk("R1 cfg", cfg_out, 8'h02);
    chk("R1 low", low_out, 8'hF6);
    chk("R1 high", high_out, 8'h3C);
    rd(2'd0, d); chk("R2 read temp", d, 8'h00);
    rd(2'd1, d); chk("R2 read cfg", d, 8'h02);
    rd(2'd2, d); chk("R2 read low", d, 8'hF6);
    rd(2'd3, d); chk("R2 read high", d, 8'h3C);
  endtask

  task automatic t_write();
    logic [7:0] d;
    wr(2'd2, 8'h05); wr(2'd3, 8'h28);
    chk("R3 low", low_out, 8'h05);
    chk("R3 high", high_out, 8'h28);
    rd(2'd3, d); chk("R2 R3 read high", d, 8'h28);
    wr(2'd0, 8'h55); chk("R4 temp write ignored", temp_out, 8'h00);
    wr(2'd1, 8'hFF); chk("R4 cfg masked", cfg_out, 8'h67);
    chk("R11 rate", {6'd0, rate_out}, 8'd3);
    chk("R11 mode", {6'd0, mode_out}, 8'd3);
    wr(2'd1, 8'h41); chk("R11 cfg", cfg_out, 8'h41);
    chk("R11 rate2", {6'd0, rate_out}, 8'd2);
    chk("R11 mode2", {6'd0, mode_out}, 8'd1);
    chk("R3 limits untouched", low_out, 8'h05);
  endtask

  task automatic t_transparent();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    conv(8'h29); chk("R5 temp", temp_out, 8'h29); chk("R6 above", cfg_out, 8'h10);
    conv(8'h28); chk("R6 R7 equal high", cfg_out, 8'h00);
    conv(8'h04); chk("R6 below", cfg_out, 8'h08);
    conv(8'h05); chk("R6 R7 equal low", cfg_out, 8'h00);
    conv(8'hFD); chk("R6 signed negative", cfg_out, 8'h08);
    chk("R5 temp neg", temp_out, 8'hFD);
    conv(8'h80); chk("R6 min", cfg_out, 8'h08);
    conv(8'h7F); chk("R7 swap flags", cfg_out, 8'h10);
    rd(2'd1, d); chk("R9 read shows flag", d, 8'h10);
    chk("R9 cleared transparent", cfg_out, 8'h00);
  endtask

  task automatic t_latched();
    logic [7:0] d;
    wr(2'd1, 8'h04);
    conv(8'h29); chk("R8 set", cfg_out, 8'h14);
    conv(8'h10); chk("R8 hold", cfg_out, 8'h14);
    conv(8'h00); chk("R8 both", cfg_out, 8'h1C);
    rd(2'd2, d); chk("R9 other read", cfg_out, 8'h1C);
    rd(2'd1, d); chk("R9 read old", d, 8'h1C);
    chk("R9 cleared", cfg_out, 8'h04);
  endtask

  task automatic t_collide();
    conv(8'h29); chk("R10 setup", cfg_out, 8'h14);
    @(negedge clk); bus_ptr = 2'd1; bus_rd = 1'b1; conv_done = 1'b1; conv_result = 8'h10;
    @(negedge clk); bus_rd = 1'b0; conv_done = 1'b0;
    chk("R10 inside wins", cfg_out, 8'h04);
    @(negedge clk); bus_rd = 1'b1; conv_done = 1'b1; conv_result = 8'h30;
    @(negedge clk); bus_rd = 1'b0; conv_done = 1'b0;
    chk("R10 above wins", cfg_out, 8'h14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_transparent();
    t_latched();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule